// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block converts a stream of decimal digits, each sent as four bits one clock at a time with the least significant bit first, into excess-3 code. Each incoming digit has three added to it. The result leaves the block bit-serially on the same clock cycle as the input bit it belongs to. The output is a Mealy function of the current state and the current input bit. No digit is buffered and no adder stage sits in the path.

The state holds two things: the bit position inside the digit, and the carry that the constant addend has produced so far. The start state is one of seven reachable codes held in three flip-flops. After the fourth bit the machine always returns to the start state. A strobe marks the cycles that carry a bit. Cycles without the strobe leave the state unchanged and drive the output low. A flag pulses on the cycle that carries the last bit of a digit, so the receiver can frame the digits.

Top module: `bcd_xs3_serial`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge) the machine is in its start state. The first strobed bit with `x_in`=0 gives `z_out`=1 in that same cycle.
- R2: On the strobed cycle that carries input bit i (i = 0 for the first bit after the start state), `z_out` equals bit i of (digit + 3). It is combinational from `x_in` in that cycle.
- R3: For every digit 0 to 9 the four output bits, taken least significant first, form digit + 3. Digit 0 (bits 0,0,0,0) gives 1,1,0,0, which is the value 3.
- R4: The state advances only on cycles with `bit_valid`=1. Any number of idle cycles between bits of a digit leaves the result unchanged.
- R5: While `bit_valid`=0, `z_out`=0 and `digit_end`=0.
- R6: `digit_end` is 1 exactly on the strobed cycle that carries bit 3 (the fourth bit) of a digit.
- R7: After the fourth bit the machine is back in the start state, so digits can follow back-to-back with no idle cycle.
- R8: A reset in the middle of a digit drops the partial digit. The next strobed bit is treated as bit 0.
- R9: The input codes 10 to 15 give the low four bits of (value + 3), and the final carry is dropped. For example, 15 gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | High on cycles that carry an input bit |
| x_in | input | 1 | Serial digit bit, least significant first |
| z_out | output | 1 | Serial excess-3 bit, same cycle as `x_in` |
| digit_end | output | 1 | Pulses on the strobed cycle of the fourth bit |

## Verification
Two kinds of internal fault are possible: a wrong bit position or a wrong carry. A wrong carry shows up on `z_out` at the next strobed bit, within the same digit. A wrong bit position moves `digit_end` and corrupts the output bits of the digit that follows. Each fault therefore shows at the ports within at most four strobed cycles. The directed cases send every legal digit, some digits with idle gaps, back-to-back digits and illegal codes, and apply a reset in the middle of a digit. That mix drives every state and every carry path, and the frame position is compared against the expected value on every strobed cycle.

// File: rtl/cx3_pkg.sv
`timescale 1ns/1ps
package cx3_pkg;

  localparam int DEF_WIDTH  = 4;
  localparam int DEF_ADDEND = 3;

  // carry out of a one-bit full adder
  function automatic logic cx3_maj(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/cx3_bit_cell.sv
`timescale 1ns/1ps
module cx3_bit_cell
  import cx3_pkg::*;
(
  input  logic x_bit,
  input  logic k_bit,
  input  logic carry_in,
  output logic sum_bit,
  output logic carry_out
);

  always_comb begin
    sum_bit   = x_bit ^ k_bit ^ carry_in;
    carry_out = cx3_maj(x_bit, k_bit, carry_in);
  end

endmodule

// File: rtl/cx3_state.sv
`timescale 1ns/1ps
module cx3_state #(
  parameter int WIDTH  = 4,
  localparam int SLOT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              carry_next,
  output logic [SLOT_W-1:0] slot_q,
  output logic              carry_q,
  output logic              last_slot
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(WIDTH - 1);

  assign last_slot = (slot_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      carry_q <= 1'b0;
    end else if (adv) begin
      if (last_slot) begin
        slot_q  <= '0;
        carry_q <= 1'b0;
      end else begin
        slot_q  <= slot_q + 1'b1;
        carry_q <= carry_next;
      end
    end
  end

endmodule

// File: rtl/bcd_xs3_serial.sv
`timescale 1ns/1ps
module bcd_xs3_serial #(
  parameter int WIDTH  = cx3_pkg::DEF_WIDTH,
  parameter int ADDEND = cx3_pkg::DEF_ADDEND
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic x_in,
  output logic z_out,
  output logic digit_end
);

  localparam int SLOT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [WIDTH-1:0] K = WIDTH'(ADDEND);

  logic [SLOT_W-1:0] slot_q;
  logic              carry_q;
  logic              last_slot;
  logic              k_bit;
  logic              sum_bit;
  logic              carry_next;
  logic [SLOT_W:0]   state_q;

  assign k_bit   = K[slot_q];
  assign state_q = {slot_q, carry_q};

  cx3_bit_cell cell_i (
    .x_bit     (x_in),
    .k_bit     (k_bit),
    .carry_in  (carry_q),
    .sum_bit   (sum_bit),
    .carry_out (carry_next)
  );

  cx3_state #(.WIDTH(WIDTH)) state_i (
    .clk        (clk),
    .rst        (rst),
    .adv        (bit_valid),
    .carry_next (carry_next),
    .slot_q     (slot_q),
    .carry_q    (carry_q),
    .last_slot  (last_slot)
  );

  assign z_out     = bit_valid & sum_bit;
  assign digit_end = bit_valid & last_slot;

endmodule

// File: rtl/bcd_xs3_serial_chk.sv
`timescale 1ns/1ps
module bcd_xs3_serial_chk #(
  parameter int WIDTH  = 4,
  parameter int ADDEND = 3,
  localparam int SLOT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            bit_valid,
  input logic            x_in,
  input logic            z_out,
  input logic            digit_end,
  input logic [SLOT_W:0] state_q
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(WIDTH - 1);
  localparam logic [WIDTH-1:0]  K    = WIDTH'(ADDEND);

  logic [SLOT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (bit_valid) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> (!z_out && !digit_end));

  assert_frame_end_R6: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> (digit_end == (cnt == LAST)));

  assert_first_bit_R1: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && cnt == '0) |-> (z_out == (x_in ^ K[0])));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(state_q));

  assert_back_to_start_R7: assert property (@(posedge clk) disable iff (rst)
    digit_end |=> (state_q == '0));

endmodule

bind bcd_xs3_serial bcd_xs3_serial_chk #(.WIDTH(WIDTH), .ADDEND(ADDEND)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bit_valid (bit_valid),
  .x_in      (x_in),
  .z_out     (z_out),
  .digit_end (digit_end),
  .state_q   (state_q)
);

// File: tb/bcd_xs3_serial_tb_top.sv
`timescale 1ns/1ps
module bcd_xs3_serial_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic x_in = 1'b0;
  logic z_out;
  logic digit_end;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bcd_xs3_serial dut_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .x_in(x_in),
    .z_out(z_out), .digit_end(digit_end)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    bit_valid = 1'b0;
    x_in = 1'b1;
    #2;
    chk({tag, " R5 z idle"}, int'(z_out), 0);
    chk({tag, " R5 end idle"}, int'(digit_end), 0);
  endtask

  task automatic send_bit(input logic b, input int pos, input int d, input string tag);
    int e;
    e = (d + 3) & 15;
    @(negedge clk);
    bit_valid = 1'b1;
    x_in = b;
    #2;
    chk($sformatf("%s R2 z d=%0d bit%0d", tag, d, pos), int'(z_out), (e >> pos) & 1);
    chk($sformatf("%s R6 end d=%0d bit%0d", tag, d, pos), int'(digit_end), (pos == 3) ? 1 : 0);
  endtask

  task automatic send_digit(input int d, input int gaps, input string tag);
    for (int i = 0; i < 4; i++) begin
      send_bit(logic'((d >> i) & 1), i, d, tag);
      for (int g = 0; g < gaps; g++) idle(tag);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    #2;
    chk("R1 R5 z after reset", int'(z_out), 0);
    chk("R1 R5 end after reset", int'(digit_end), 0);
    send_bit(1'b0, 0, 0, "R1 first bit");
    send_bit(1'b0, 1, 0, "R3 zero pair");
    send_bit(1'b0, 2, 0, "R3 zero");
    send_bit(1'b0, 3, 0, "R3 zero");
    idle("R1");
  endtask

  task automatic t_all_digits();
    for (int d = 0; d < 10; d++) send_digit(d, 0, "R3 R7 stream");
    idle("R3");
  endtask

  task automatic t_gaps();
    send_digit(7, 2, "R4 gap");
    send_digit(9, 1, "R4 gap");
    send_digit(4, 3, "R4 gap");
  endtask

  task automatic t_mid_reset();
    send_bit(1'b1, 0, 9, "R8 partial");
    send_bit(1'b0, 1, 9, "R8 partial");
    do_reset();
    send_digit(0, 0, "R8 after reset");
    send_digit(5, 0, "R8 after reset");
  endtask

  task automatic t_illegal();
    for (int d = 10; d < 16; d++) send_digit(d, 0, "R9 wrap");
    send_digit(2, 0, "R9 R7 follow");
    idle("R9");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_all_digits();
    t_gaps();
    t_mid_reset();
    t_illegal();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule